// File: doc/BRIEF.md
# Min-Max Check Node Processor

This block evaluates one parity check of a binary LDPC decoder that runs the min-max message-passing rule. The check joins six variable nodes. One start pulse loads the six incoming variable-to-check messages. The block then returns the six outgoing check-to-variable messages, one per clock cycle, in edge order.

Each outgoing message for edge k uses only the other five incoming messages. Each of those five messages has a hard decision and a reliability. The block lists the 16 five-bit configurations that would satisfy the check if edge k took the value opposite to the sign the other five messages favour. It scores each configuration by the largest penalty among its five positions. The smallest of the 16 scores becomes the magnitude of the reply.

A sequencer outside the block supplies the messages and collects the replies. A one-cycle done pulse marks the end of each group of six replies.

Top module: `cnu_minmax`

## Requirements
- R1: After reset, valid_o and done_o are 0, result_o is 0 and edge_o is 0.
- R2: When start_i is sampled high while the block is idle, the block presents six results on the six cycles that follow, with valid_o high and edge_o counting 0, 1, 2, 3, 4, 5.
- R3: An input's hard decision is its sign bit (1 means negative). Its magnitude is its absolute value, and -128 is taken as 127. In a configuration, a position costs 0 when its bit equals the hard decision of that input, and otherwise costs the input's magnitude.
- R4: The magnitude of result k is the minimum, over the 16 configurations of the five other inputs whose parity equals the inverse of their hard-decision XOR, of the maximum position cost in that configuration.
- R5: The sign of result k is the XOR of the other five hard decisions. result_o is the two's-complement negation of the magnitude when that XOR is 1, and the magnitude itself when it is 0.
- R6: The message on edge k has no effect on result k.
- R7: done_o is high for exactly one cycle, on the cycle after the result for edge 5 is shown.
- R8: result_o never takes the value -128, even when inputs are -128.
- R9: start_i pulses and changes on msg_i while a group of six results is in progress have no effect on that group. The inputs are captured only on the accepting start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the messages and begin a group of six results |
| msg_i | input | 6x8 | Incoming messages, signed, edge 0 in the low byte |
| result_o | output | 8 | Outgoing message, signed |
| edge_o | output | 3 | Edge index of result_o |
| valid_o | output | 1 | result_o and edge_o are valid |
| done_o | output | 1 | One-cycle pulse after the last result |

## Verification
Each result depends only on the captured message register and the edge counter. A corrupted edge index therefore shows in the very next valid cycle, as a wrong edge_o or as a result taken from the wrong five inputs. A fault in the parity fix-up of the configurations or in the cost selection shows as a wrong magnitude in the same cycle. Typical faults are a 0 magnitude where the hard decisions alone already satisfy the check, or the largest magnitude instead of the smallest. A sequencer that leaves or re-enters its run state early shows as a missing, doubled or misplaced done_o within seven cycles of start_i.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  localparam int unsigned MSG_W_DEF   = 8;
  localparam int unsigned CHK_DEG_DEF = 6;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cnu_state_e;
endpackage

// File: rtl/cnu_edge_select.sv
// Gathers the inputs other than edge sel_i: hard decisions, saturated magnitudes, hard-decision parity.
module cnu_edge_select #(
  parameter int unsigned MSG_W   = 8,
  parameter int unsigned CHK_DEG = 6,
  localparam int unsigned OTH    = CHK_DEG - 1,
  localparam int unsigned MW     = MSG_W - 1,
  localparam int unsigned IDX_W  = $clog2(CHK_DEG)
) (
  input  logic [CHK_DEG-1:0][MSG_W-1:0] msgs_i,
  input  logic [IDX_W-1:0]              sel_i,
  output logic [OTH-1:0][MW-1:0]        mag_o,
  output logic [OTH-1:0]                hard_o,
  output logic                          par_o
);
  logic [OTH-1:0][MSG_W-1:0] oth;

  always_comb begin
    for (int j = 0; j < OTH; j++) begin
      oth[j] = (j < int'(sel_i)) ? msgs_i[j] : msgs_i[j+1];
    end
  end

  for (genvar j = 0; j < OTH; j++) begin : g_mag
    logic [MSG_W-1:0] neg;
    logic             is_min;
    assign neg       = ~oth[j] + MSG_W'(1);
    assign is_min    = (oth[j] == {1'b1, {MW{1'b0}}});
    assign hard_o[j] = oth[j][MSG_W-1];
    assign mag_o[j]  = !oth[j][MSG_W-1] ? oth[j][MW-1:0]
                     : (is_min ? {MW{1'b1}} : neg[MW-1:0]);
  end

  assign par_o = ^hard_o;
endmodule

// File: rtl/cnu_cfg_cost.sv
// Largest mismatch penalty for one bit configuration.
module cnu_cfg_cost #(
  parameter int unsigned OTH = 5,
  parameter int unsigned MW  = 7
) (
  input  logic [OTH-1:0]         cfg_i,
  input  logic [OTH-1:0]         hard_i,
  input  logic [OTH-1:0][MW-1:0] mag_i,
  output logic [MW-1:0]          max_o
);
  always_comb begin
    max_o = '0;
    for (int j = 0; j < OTH; j++) begin
      if (cfg_i[j] != hard_i[j] && mag_i[j] > max_o) max_o = mag_i[j];
    end
  end
endmodule

// File: rtl/cnu_min_reduce.sv
// Pairwise minimum tree; odd leftovers pass through.
module cnu_min_reduce #(
  parameter int unsigned N  = 16,
  parameter int unsigned MW = 7
) (
  input  logic [N-1:0][MW-1:0] vals_i,
  output logic [MW-1:0]        min_o
);
  if (N == 1) begin : g_leaf
    assign min_o = vals_i[0];
  end else begin : g_node
    localparam int unsigned NL = N / 2;
    localparam int unsigned NR = N - NL;
    logic [MW-1:0] lo_min, hi_min;
    cnu_min_reduce #(.N(NL), .MW(MW)) u_lo (.vals_i(vals_i[NL-1:0]), .min_o(lo_min));
    cnu_min_reduce #(.N(NR), .MW(MW)) u_hi (.vals_i(vals_i[N-1:NL]), .min_o(hi_min));
    assign min_o = (hi_min < lo_min) ? hi_min : lo_min;
  end
endmodule

// File: rtl/cnu_minmax.sv
module cnu_minmax
  import cnu_pkg::*;
#(
  parameter int unsigned MSG_W   = MSG_W_DEF,
  parameter int unsigned CHK_DEG = CHK_DEG_DEF
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [CHK_DEG-1:0][MSG_W-1:0] msg_i,
  output logic [MSG_W-1:0]              result_o,
  output logic [$clog2(CHK_DEG)-1:0]    edge_o,
  output logic                          valid_o,
  output logic                          done_o
);
  localparam int unsigned OTH   = CHK_DEG - 1;
  localparam int unsigned NCFG  = (1 << OTH) / 2;
  localparam int unsigned MW    = MSG_W - 1;
  localparam int unsigned IDX_W = $clog2(CHK_DEG);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHK_DEG - 1);

  cnu_state_e                   state_q;
  logic [CHK_DEG-1:0][MSG_W-1:0] msg_q;
  logic [IDX_W-1:0]             idx_q;

  logic [OTH-1:0][MW-1:0] mag;
  logic [OTH-1:0]         hard;
  logic                   par;
  logic [NCFG-1:0][MW-1:0] cfg_max;
  logic [MW-1:0]          min_mag;
  logic [MSG_W-1:0]       pos_val;
  logic [MSG_W-1:0]       res_d;

  cnu_edge_select #(.MSG_W(MSG_W), .CHK_DEG(CHK_DEG)) u_sel (
    .msgs_i (msg_q),
    .sel_i  (idx_q),
    .mag_o  (mag),
    .hard_o (hard),
    .par_o  (par)
  );

  // Configurations of the competing hypothesis: parity must equal ~par.
  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam logic [OTH-2:0] LOW = (OTH-1)'(g);
    logic [OTH-1:0] cfg;
    assign cfg = {(^LOW) ^ ~par, LOW};
    cnu_cfg_cost #(.OTH(OTH), .MW(MW)) u_cost (
      .cfg_i  (cfg),
      .hard_i (hard),
      .mag_i  (mag),
      .max_o  (cfg_max[g])
    );
  end

  cnu_min_reduce #(.N(NCFG), .MW(MW)) u_min (
    .vals_i (cfg_max),
    .min_o  (min_mag)
  );

  assign pos_val = {1'b0, min_mag};
  assign res_d   = par ? (~pos_val + MSG_W'(1)) : pos_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      msg_q    <= '0;
      idx_q    <= '0;
      result_o <= '0;
      edge_o   <= '0;
      valid_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      done_o  <= valid_o && (edge_o == LAST);
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            msg_q   <= msg_i;
            idx_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          result_o <= res_d;
          edge_o   <= idx_q;
          valid_o  <= 1'b1;
          if (idx_q == LAST) state_q <= ST_IDLE;
          else               idx_q   <= idx_q + IDX_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cnu_minmax_chk.sv
module cnu_minmax_chk #(
  parameter int unsigned MSG_W   = 8,
  parameter int unsigned CHK_DEG = 6
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [MSG_W-1:0]           result_o,
  input logic [$clog2(CHK_DEG)-1:0] edge_o,
  input logic                       valid_o,
  input logic                       done_o
);
  localparam int unsigned IDX_W = $clog2(CHK_DEG);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHK_DEG - 1);

  p_first_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> edge_o == '0);

  p_edge_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && edge_o != LAST) |=> (valid_o && edge_o == $past(edge_o) + IDX_W'(1)));

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(valid_o) && $past(edge_o) == LAST));

  p_no_full_neg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> result_o != {1'b1, {(MSG_W-1){1'b0}}});
endmodule

bind cnu_minmax cnu_minmax_chk #(.MSG_W(MSG_W), .CHK_DEG(CHK_DEG)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .result_o (result_o),
  .edge_o   (edge_o),
  .valid_o  (valid_o),
  .done_o   (done_o)
);

// File: tb/cnu_minmax_tb.sv
module cnu_minmax_tb;
  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [5:0][7:0] msg_i = '0;
  logic [7:0]      result_o;
  logic [2:0]      edge_o;
  logic            valid_o;
  logic            done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  cnu_minmax u_dut (
    .clk_i, .rst_ni, .start_i, .msg_i, .result_o, .edge_o, .valid_o, .done_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference: the check is satisfied by one flip; cheapest flip is the smallest magnitude.
  function automatic logic [7:0] ref_msg(input logic [5:0][7:0] m, input int k);
    int mn = 127;
    bit s = 1'b0;
    for (int j = 0; j < 6; j++) begin
      if (j != k) begin
        int v = $signed(m[j]);
        int a = (v < 0) ? ((v == -128) ? 127 : -v) : v;
        s ^= m[j][7];
        if (a < mn) mn = a;
      end
    end
    return s ? 8'(-mn) : 8'(mn);
  endfunction

  task automatic run_frame(input logic [5:0][7:0] m, input bit disturb);
    @(negedge clk_i);
    msg_i   = m;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (disturb) msg_i = {$urandom, $urandom};
    for (int k = 0; k < 6; k++) begin
      if (disturb && k == 2) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      check("R2 valid", valid_o, 1);
      check("R2 edge", edge_o, k);
      check(disturb ? "R9 R4 R5 result" : "R4 R5 result", $signed(result_o),
            $signed(ref_msg(m, k)));
      check("R8 not -128", (result_o == 8'h80), 0);
      if (k == 5) check("R7 done early", done_o, 0);
    end
    @(negedge clk_i);
    check("R7 done", done_o, 1);
    check("R2 valid drops", valid_o, 0);
    @(negedge clk_i);
    check("R7 done one cycle", done_o, 0);
    check("R9 no restart", valid_o, 0);
  endtask

  initial begin
    repeat (10000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [5:0][7:0] m;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    check("R1 valid", valid_o, 0);
    check("R1 done", done_o, 0);
    check("R1 result", result_o, 0);
    check("R1 edge", edge_o, 0);
    rst_ni = 1'b1;

    // R3 R4: all positive, distinct magnitudes
    run_frame({8'd60, 8'd50, 8'd40, 8'd30, 8'd20, 8'd10}, 1'b0);
    // R8: all -128 saturate to magnitude 127
    run_frame({6{8'h80}}, 1'b0);
    // R3: zero inputs give zero magnitude
    run_frame({8'd5, 8'd0, 8'd7, 8'd9, 8'd3, 8'd4}, 1'b0);
    // R5 R6: one tiny input per edge; it must not shape its own reply
    for (int t = 0; t < 6; t++) begin
      m = {6{8'd100}};
      m[t] = 8'hFF;
      run_frame(m, 1'b0);
    end
    // R5: mixed signs
    run_frame({8'h81, 8'd2, 8'hF0, 8'd127, 8'hC0, 8'd1}, 1'b0);
    // R9: disturbance during a run
    run_frame({8'd11, 8'hEE, 8'd33, 8'hBB, 8'd55, 8'h99}, 1'b1);
    // Constrained random
    for (int r = 0; r < 60; r++) begin
      for (int j = 0; j < 6; j++) begin
        case ($urandom_range(0, 7))
          0: m[j] = 8'h80;
          1: m[j] = 8'd0;
          2: m[j] = 8'd127;
          default: m[j] = 8'($urandom);
        endcase
      end
      run_frame(m, r % 5 == 0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule